// File: doc/BRIEF.md
# Debug-Port Flash Mass-Erase Controller

This block sits behind a debug access port and lets an external debugger wipe the whole flash of a device, including one whose contents are secured. It has two byte-wide registers on a simple register bus. One address selects a writable control register. The other selects a read-only status register. A one-bit address picks between them, and reads return data combinationally in the same cycle.

A debugger starts an erase by setting the request bit of the control register. It usually sets the system-reset request and the core-hold bit in the same write, then drops the system-reset request and polls the request bit. The block sends a single-cycle start pulse to the flash controller, but only when erasing is permitted and the flash is ready. It acknowledges the request in status and waits for a completion pulse. That pulse clears the request and removes the security state.

Erasing is permitted when the device is not secured or when the mass-erase-enable input is high. If a request arrives while erasing is forbidden, the block locks it out. The request bit then stays set until a system reset, so a polling debugger times out instead of seeing a false success.

Top module: `dbg_erase_unit`

## Requirements
- R1: After `rst_n` is released, the control register reads 0x00, the status acknowledge (bit 0) reads 0, and the latched security flag (status bit 2) reads 1 until a system reset loads it from `secure_in`.
- R2: A control write stores data bit 3 (system-reset request, driven on `sys_rst_req`) and data bit 4 (core hold, driven on `core_hold`). Every other control bit reads as 0; for example, writing 0xFF reads back 0x19.
- R3: Control bit 0 is set by writing a 1. Writing a 0 to it never clears it; only erase completion or a system reset clears it.
- R4: While a request is pending, not yet acknowledged and not locked out, `erase_start` is high for exactly one cycle. This happens in the first cycle in which erasing is permitted (security flag clear or `erase_en_in` high) and `flash_ready_in` is high. That cycle can be the one right after the write's clock edge.
- R5: Status bit 0 (acknowledge) becomes 1 on the clock edge that ends the `erase_start` cycle. It stays 1 until the request bit clears.
- R6: An `erase_done` pulse while the acknowledge is set clears control bit 0, the acknowledge and the security flag on that edge. An `erase_done` pulse with no acknowledge set changes nothing.
- R7: A request seen while the security flag is set and `erase_en_in` is low is locked out. No `erase_start` is ever issued for it, even if `erase_en_in` later rises, and control bit 0 stays 1.
- R8: While `sys_rst_n` is low, every control bit, the acknowledge and the lock-out are cleared, register writes are ignored, and the security flag loads from `secure_in`.
- R9: The status register reads bit 1 = `flash_ready_in`, bit 2 = security flag, bit 3 = 0 while `sys_rst_n` is low or control bit 3 is set (1 otherwise), and bit 5 = `erase_en_in`. Bits 4, 6 and 7 read 0.
- R10: Writes with `reg_sel` = 1 (the status address) change no register.
- R11: `reg_rdata` shows the register selected by `reg_sel` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| reg_sel | input | 1 | Register select: 0 control, 1 status |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| sys_rst_n | input | 1 | System reset, active low, sampled on the clock |
| secure_in | input | 1 | Device security state, loaded during system reset |
| erase_en_in | input | 1 | Mass erase permitted while secured |
| flash_ready_in | input | 1 | Flash controller ready for a command |
| erase_done | input | 1 | Erase completion pulse from the flash controller |
| erase_start | output | 1 | Single-cycle erase command to the flash controller |
| sys_rst_req | output | 1 | System reset requested by the debugger |
| core_hold | output | 1 | Core held in reset by the debugger |

## Verification
Each result has a fixed delay after its stimulus. A register write or an `erase_done` pulse takes effect on the next clock edge. `erase_start` is high during the cycle that follows that edge. The acknowledge appears one edge later. Reads are valid in the same cycle. The bench drives its inputs on the falling edge and compares a behavioural reference model against every output 15 ns after each rising edge, when all of these values have settled. Directed checks then count start pulses across whole polling windows. They also read the registers back after each write, done pulse and system reset, so that the lock-out and the status-write rule are seen at the ports.

// File: rtl/dbg_erase_pkg.sv
package dbg_erase_pkg;
  localparam int REG_W    = 8;
  // control bit positions (the unlock sequence depends on them)
  localparam int C_REQ    = 0;
  localparam int C_SRST   = 3;
  localparam int C_HOLD   = 4;
  // status bit positions
  localparam int S_ACK    = 0;
  localparam int S_FRDY   = 1;
  localparam int S_SEC    = 2;
  localparam int S_NRST   = 3;
  localparam int S_MEEN   = 5;

  function automatic logic [REG_W-1:0] pack_ctrl(logic req, logic srst, logic hold);
    logic [REG_W-1:0] v;
    v = '0;
    v[C_REQ]  = req;
    v[C_SRST] = srst;
    v[C_HOLD] = hold;
    return v;
  endfunction

  function automatic logic [REG_W-1:0] pack_status(logic ack, logic frdy, logic sec,
                                                   logic nrst, logic meen);
    logic [REG_W-1:0] v;
    v = '0;
    v[S_ACK]  = ack;
    v[S_FRDY] = frdy;
    v[S_SEC]  = sec;
    v[S_NRST] = nrst;
    v[S_MEEN] = meen;
    return v;
  endfunction

  function automatic logic erase_permitted(logic sec, logic meen);
    return !sec || meen;
  endfunction
endpackage

// File: rtl/dbg_erase_ctrl_reg.sv
module dbg_erase_ctrl_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic sys_rst_n,
  input  logic wr_ctrl,
  input  logic set_req,
  input  logic srst_d,
  input  logic hold_d,
  input  logic clr_req,
  output logic req_q,
  output logic srst_q,
  output logic hold_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      srst_q <= 1'b0;
      hold_q <= 1'b0;
    end else if (!sys_rst_n) begin
      req_q  <= 1'b0;
      srst_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        srst_q <= srst_d;
        hold_q <= hold_d;
      end
      if (clr_req)
        req_q <= 1'b0;
      else if (wr_ctrl && set_req)
        req_q <= 1'b1;
    end
  end
endmodule

// File: rtl/dbg_erase_seq.sv
module dbg_erase_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic sys_rst_n,
  input  logic req,
  input  logic secure_in,
  input  logic meen,
  input  logic frdy,
  input  logic done_in,
  output logic issue,
  output logic done_ok,
  output logic ack_q,
  output logic sec_q,
  output logic blk_q
);
  import dbg_erase_pkg::*;

  logic permitted;
  logic waiting;
  logic blk_set;

  assign permitted = erase_permitted(sec_q, meen);
  assign waiting   = req && !ack_q && !blk_q;
  assign issue     = waiting && permitted && frdy;
  assign blk_set   = waiting && !permitted;
  assign done_ok   = done_in && ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      blk_q <= 1'b0;
      sec_q <= 1'b1;
    end else if (!sys_rst_n) begin
      ack_q <= 1'b0;
      blk_q <= 1'b0;
      sec_q <= secure_in;
    end else begin
      if (done_ok) begin
        ack_q <= 1'b0;
        sec_q <= 1'b0;
      end else if (issue) begin
        ack_q <= 1'b1;
      end
      if (blk_set)
        blk_q <= 1'b1;
    end
  end
endmodule

// File: rtl/dbg_erase_unit.sv
module dbg_erase_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_sel,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       sys_rst_n,
  input  logic       secure_in,
  input  logic       erase_en_in,
  input  logic       flash_ready_in,
  input  logic       erase_done,
  output logic       erase_start,
  output logic       sys_rst_req,
  output logic       core_hold
);
  import dbg_erase_pkg::*;

  logic wr_ctrl;
  logic req_q, srst_q, hold_q;
  logic issue, done_ok, ack_q, sec_q, blk_q;
  logic sys_nrst_view;
  logic wdata_unused;

  assign wr_ctrl      = reg_wr && !reg_sel;
  assign wdata_unused = ^{reg_wdata[7:5], reg_wdata[2:1]};

  dbg_erase_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .sys_rst_n(sys_rst_n),
    .wr_ctrl  (wr_ctrl),
    .set_req  (reg_wdata[C_REQ]),
    .srst_d   (reg_wdata[C_SRST]),
    .hold_d   (reg_wdata[C_HOLD]),
    .clr_req  (done_ok),
    .req_q    (req_q),
    .srst_q   (srst_q),
    .hold_q   (hold_q)
  );

  dbg_erase_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .sys_rst_n(sys_rst_n),
    .req      (req_q),
    .secure_in(secure_in),
    .meen     (erase_en_in),
    .frdy     (flash_ready_in),
    .done_in  (erase_done),
    .issue    (issue),
    .done_ok  (done_ok),
    .ack_q    (ack_q),
    .sec_q    (sec_q),
    .blk_q    (blk_q)
  );

  assign sys_nrst_view = sys_rst_n && !srst_q;
  assign erase_start   = issue;
  assign sys_rst_req   = srst_q;
  assign core_hold     = hold_q;
  assign reg_rdata     = reg_sel
                       ? pack_status(ack_q, flash_ready_in, sec_q, sys_nrst_view, erase_en_in)
                       : pack_ctrl(req_q, srst_q, hold_q);
endmodule

// File: rtl/dbg_erase_chk.sv
module dbg_erase_chk (
  input logic clk,
  input logic rst_n,
  input logic sys_rst_n,
  input logic reg_sel,
  input logic reg_wr,
  input logic erase_start,
  input logic erase_done,
  input logic erase_en_in,
  input logic req,
  input logic ack,
  input logic sec,
  input logic blk,
  input logic srst,
  input logic hold
);
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start);  // R4
  AST_ACK_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_start && sys_rst_n) |=> ack);  // R5
  AST_NO_START_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> (erase_en_in || !sec));  // R7
  AST_LOCK_KEEPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (blk && sys_rst_n) |=> req);  // R7
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_done && ack && sys_rst_n) |=> (!req && !ack && !sec));  // R6
  AST_SYSRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_rst_n |=> (!req && !srst && !hold && !ack && !blk));  // R8
  AST_STATUS_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel && sys_rst_n) |=> ($stable(srst) && $stable(hold)));  // R10
endmodule

bind dbg_erase_unit dbg_erase_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sys_rst_n  (sys_rst_n),
  .reg_sel    (reg_sel),
  .reg_wr     (reg_wr),
  .erase_start(erase_start),
  .erase_done (erase_done),
  .erase_en_in(erase_en_in),
  .req        (req_q),
  .ack        (ack_q),
  .sec        (sec_q),
  .blk        (blk_q),
  .srst       (srst_q),
  .hold       (hold_q)
);

// File: tb/dbg_erase_unit_tb.sv
module dbg_erase_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_sel = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       sys_rst_n = 1'b0;
  logic       secure_in = 1'b1;
  logic       erase_en_in = 1'b0;
  logic       flash_ready_in = 1'b1;
  logic       erase_done = 1'b0;
  logic       erase_start, sys_rst_req, core_hold;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int starts = 0;
  bit finished = 0;

  // reference model state
  bit m_req, m_srst, m_hold, m_ack, m_blk;
  bit m_sec = 1;

  always #10 clk = ~clk;  // 50 MHz

  dbg_erase_unit u_dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sys_rst_n(sys_rst_n),
    .secure_in(secure_in), .erase_en_in(erase_en_in),
    .flash_ready_in(flash_ready_in), .erase_done(erase_done),
    .erase_start(erase_start), .sys_rst_req(sys_rst_req), .core_hold(core_hold)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit m_start();
    return m_req && !m_ack && !m_blk && (!m_sec || erase_en_in) && flash_ready_in;
  endfunction

  function automatic int m_read(bit sel);
    int v;
    if (sel)
      v = int'(m_ack) | (int'(flash_ready_in) << 1) | (int'(m_sec) << 2)
        | (int'(sys_rst_n && !m_srst) << 3) | (int'(erase_en_in) << 5);
    else
      v = int'(m_req) | (int'(m_srst) << 3) | (int'(m_hold) << 4);
    return v;
  endfunction

  // model update on the rising edge
  always @(posedge clk) begin
    bit d, acc, lock;
    if (!rst_n) begin
      m_req = 0; m_srst = 0; m_hold = 0; m_ack = 0; m_blk = 0; m_sec = 1;
    end else if (!sys_rst_n) begin
      m_req = 0; m_srst = 0; m_hold = 0; m_ack = 0; m_blk = 0; m_sec = secure_in;
    end else begin
      d    = erase_done && m_ack;
      acc  = m_start();
      lock = m_req && !m_ack && !m_blk && m_sec && !erase_en_in;
      if (reg_wr && !reg_sel) begin
        m_srst = reg_wdata[3];
        m_hold = reg_wdata[4];
      end
      if (d) begin
        m_req = 0; m_ack = 0; m_sec = 0;
      end else begin
        if (reg_wr && !reg_sel && reg_wdata[0]) m_req = 1;
        if (acc) m_ack = 1;
      end
      if (lock) m_blk = 1;
    end
  end

  // per-cycle comparison, 15 ns after each rising edge
  always begin
    @(posedge clk);
    #15;
    if (erase_start) starts++;
    check("R11 readback", reg_rdata, m_read(reg_sel));
    check("R4 erase_start", erase_start, m_start());
    check("R2 outputs", {sys_rst_req, core_hold}, {m_srst, m_hold});
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<50000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(bit sel, logic [7:0] d);
    @(negedge clk); reg_sel = sel; reg_wr = 1; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_wdata = 8'h00;
  endtask

  task automatic rd(bit sel, output int v);
    reg_sel = sel; #2; v = int'(reg_rdata);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sys_reset(bit sec);
    @(negedge clk); secure_in = sec; sys_rst_n = 0;
    idle(2); sys_rst_n = 1;
  endtask

  initial begin
    int v, s0;
    idle(3);
    rst_n = 1;
    rd(0, v); check("R1 ctrl after reset", v, 8'h00);
    rd(1, v); check("R1 sec before sysreset", (v >> 2) & 1, 1);
    check("R1 ack after reset", v & 1, 0);
    check("R9 nrst low in sysreset", (v >> 3) & 1, 0);
    wr(0, 8'h19);
    rd(0, v); check("R8 write ignored in sysreset", v, 8'h00);
    sys_rst_n = 1;
    idle(1);
    rd(1, v); check("R9 status secured", v, 8'h0E);

    // R2 reserved bits
    wr(0, 8'hFF);
    rd(0, v); check("R2 write FF", v & 8'hFE, 8'h18);
    rd(1, v); check("R9 nrst low on srst bit", (v >> 3) & 1, 0);
    sys_reset(1);
    rd(0, v); check("R8 ctrl cleared", v, 8'h00);

    // R10 status write ignored
    wr(1, 8'hFF);
    rd(0, v); check("R10 ctrl after status write", v, 8'h00);

    // R7 locked-out request
    erase_en_in = 0;
    s0 = starts;
    wr(0, 8'h19); wr(0, 8'h11);
    idle(20);
    check("R7 no start when locked", starts - s0, 0);
    rd(0, v); check("R7 req stays", v & 1, 1);
    wr(0, 8'h00);
    rd(0, v); check("R3 zero write no clear", v & 1, 1);
    erase_en_in = 1;
    idle(10);
    check("R7 no start after enable", starts - s0, 0);
    rd(1, v); check("R7 ack stays 0", v & 1, 0);
    sys_reset(1);
    rd(0, v); check("R8 locked req cleared", v & 1, 0);

    // R4 waits for flash ready, then R5/R6
    flash_ready_in = 0;
    s0 = starts;
    wr(0, 8'h19);
    idle(5);
    check("R4 no start before ready", starts - s0, 0);
    flash_ready_in = 1; #2;
    check("R4 start visible when ready", erase_start, 1);
    @(negedge clk); #2;
    check("R4 start single cycle", erase_start, 0);
    rd(1, v); check("R5 ack set", v & 1, 1);
    wr(0, 8'h11);
    rd(0, v); check("R3 req kept before done", v & 1, 1);
    idle(5);
    check("R4 exactly one start", starts - s0, 1);
    erase_done = 1; @(negedge clk); erase_done = 0;
    rd(0, v); check("R6 req cleared", v, 8'h10);
    rd(1, v); check("R6 ack and sec cleared", v & 8'h05, 0);
    wr(0, 8'h00);

    // R6 stray done ignored; erase with sec clear and enable low
    erase_en_in = 0;
    erase_done = 1; @(negedge clk); erase_done = 0;
    rd(0, v); check("R6 stray done", v, 8'h00);
    s0 = starts;
    wr(0, 8'h01);
    check("R4 start when unsecured", erase_start, 1);
    idle(3);
    check("R4 one start unsecured", starts - s0, 1);
    erase_done = 1; @(negedge clk); erase_done = 0;
    rd(0, v); check("R6 cleared again", v, 8'h00);

    sys_reset(0);
    rd(1, v); check("R8 sec loads 0", (v >> 2) & 1, 0);
    idle(4);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule